// File: doc/BRIEF.md
# Two-Stage Translation Result Checker

This block takes the finished outcome of a stage-1 and a stage-2 address walk and turns it into one final fault verdict and one final set of memory attributes. It does no walking and computes no permissions itself: the attributes each stage found, the permission-check result of each stage, and a debug-match flag all arrive as inputs. The block checks them in a fixed order and reports only the first fault it finds.

Stage 1 is checked first: the load/store-multiple trap, the Device alignment rule, the permission result, and then instruction fetch from Device memory. Stage 2 is checked only when stage 1 is clean and stage 2 is enabled. A stage-2 lookup that serves a stage-1 table fetch and lands on Device memory is either faulted or quietly rewritten to Normal non-cacheable shareable memory. A debug check closes the sequence. The verdict is registered and appears one cycle after `in_valid`, with `out_valid`.

Top module: `xlat_result_chk`

## Requirements
- R1: Outputs are registered. `out_valid` is high in the cycle after a cycle with `in_valid` high. The other outputs change only after a valid input and hold their values when `in_valid` is low. Reset clears all outputs to 0.
- R2: Stage 1 is enabled when `s1_mmu_en` is 1 and either `s2_present` is 0 or both `trap_general` and `dflt_cache` are 0. `out_guarded` is `s1_guard` on an instruction fetch with stage 1 enabled, and 0 in every other case.
- R3: A stage-1 alignment fault (code 1, stage 0) is raised in two cases. The first is a load/store-multiple access (`lsm_access`=1) to Device memory that is not gathering-reordering-early-ack (attr bit 5 = 1, bit 4 = 0) while `lsm_trap_dis` is 0. The second is an access to Device memory that is either unaligned and not an instruction fetch, or a zero-block operation.
- R4: When no earlier fault exists, `s1_perm_fault` gives permission fault code 2 with stage 0. This applies only when stage 1 is enabled.
- R5: An instruction fetch from Device memory with no earlier fault gives code 4 (instruction-device). This uses stage 0 for the stage-1 attributes, and stage 1 for the stage-2 attributes when the fetch is not a table fetch.
- R6: Stage 2 runs only if stage 1 gives no fault and `s2_present`=1 and (`s2_vm`=1 or `dflt_cache`=1). When it runs, its alignment rule gives code 1, followed by `s2_perm_fault` giving code 2, both with stage 1.
- R7: When stage 2 runs with `s2_for_table`=1, has no fault so far, and has Device attributes, `ptw_protect`=1 gives code 2 with stage 1. Otherwise the final attributes become 6'b001111 (Normal, inner and outer non-cacheable, shareable, outer-shareable).
- R8: When no fault exists and the access type is not table walk (4), I-cache maintenance (5) or address translation (6), `dbg_hit`=1 gives code 3 with stage 0.
- R9: Access type encoding: 0 load, 1 store, 2 instruction fetch, 3 zero-block, 4 table walk, 5 I-cache maintenance, 6 address translation, 7 atomic. Attribute bits: [5] Device, [4] gathering-reordering-early-ack, [3] inner non-cacheable, [2] outer non-cacheable, [1] shareable, [0] outer-shareable. `out_attr` takes the stage-2 attributes (after any rewrite) when stage 2 ran, and the stage-1 attributes otherwise.
- R10: `out_code` is always one of 0..4. Codes from later checks are masked by the first fault found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Inputs carry a walk result |
| acc_type | input | 3 | Access type (R9 encoding) |
| aligned | input | 1 | Access is aligned |
| lsm_access | input | 1 | Access is a load/store-multiple |
| lsm_trap_dis | input | 1 | Disables the load/store-multiple Device trap |
| s1_mmu_en | input | 1 | Stage-1 MMU enable |
| s2_present | input | 1 | Stage 2 exists in this regime |
| trap_general | input | 1 | Trap-general control |
| dflt_cache | input | 1 | Default-cacheable control |
| s2_vm | input | 1 | Stage-2 enable control |
| s1_attr | input | 6 | Stage-1 attributes |
| s1_perm_fault | input | 1 | Stage-1 permission check failed |
| s1_guard | input | 1 | Stage-1 guarded-page bit |
| s2_attr | input | 6 | Stage-2 attributes |
| s2_perm_fault | input | 1 | Stage-2 permission check failed |
| s2_for_table | input | 1 | Stage-2 lookup serves a stage-1 table fetch |
| ptw_protect | input | 1 | Fault table fetches that land on Device memory |
| dbg_hit | input | 1 | Debug match for this access |
| out_valid | output | 1 | Result strobe |
| out_code | output | 3 | Fault code: 0 none, 1 alignment, 2 permission, 3 debug, 4 instruction-device |
| out_stage | output | 1 | 1 if stage 2 raised the fault |
| out_attr | output | 6 | Final attributes |
| out_guarded | output | 1 | Guarded-page indication |

## Verification
The hardest case to reach is the table-fetch rewrite. It needs stage 1 to pass every one of its checks, stage 2 to be enabled and present, the stage-2 attributes to be Device, and neither stage-2 alignment nor stage-2 permission to fire. Random stimulus with even bit weights rarely lines all of these up. The bench therefore runs directed cycles that build this clean path with `ptw_protect` at both values, and then biases its random phase so that stage-1 faults are rare and the stage-2 controls are usually on.

// File: rtl/xlat_result_chk.sv
module xlat_result_chk #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    acc_type,
  input  logic          aligned,
  input  logic          lsm_access,
  input  logic          lsm_trap_dis,
  input  logic          s1_mmu_en,
  input  logic          s2_present,
  input  logic          trap_general,
  input  logic          dflt_cache,
  input  logic          s2_vm,
  input  logic [AW-1:0] s1_attr,
  input  logic          s1_perm_fault,
  input  logic          s1_guard,
  input  logic [AW-1:0] s2_attr,
  input  logic          s2_perm_fault,
  input  logic          s2_for_table,
  input  logic          ptw_protect,
  input  logic          dbg_hit,
  output logic          out_valid,
  output logic [2:0]    out_code,
  output logic          out_stage,
  output logic [AW-1:0] out_attr,
  output logic          out_guarded
);
  localparam logic [2:0] C_NONE = 3'd0, C_ALIGN = 3'd1, C_PERM = 3'd2,
                         C_DBG = 3'd3, C_IDEV = 3'd4;
  localparam logic [AW-1:0] NC_ATTR = AW'(6'b001111);

  wire ifetch  = acc_type == 3'd2;
  wire zva     = acc_type == 3'd3;
  wire dbg_ok  = !(acc_type inside {3'd4, 3'd5, 3'd6});
  wire s1_en   = s1_mmu_en && (!s2_present || (!trap_general && !dflt_cache));
  wire s2_en   = s2_present && (s2_vm || dflt_cache);
  wire dev1    = s1_attr[5];
  wire dev2    = s2_attr[5];
  wire misal   = (!aligned && !ifetch) || zva;

  logic [2:0]    code1, code2, code;
  logic          stage;
  logic [AW-1:0] attr2, attr;

  always_comb begin
    code1 = C_NONE;
    if (lsm_access && dev1 && !s1_attr[4] && !lsm_trap_dis) code1 = C_ALIGN;
    else if (misal && dev1)                                  code1 = C_ALIGN;
    else if (s1_en && s1_perm_fault)                         code1 = C_PERM;
    else if (ifetch && dev1)                                 code1 = C_IDEV;
  end

  always_comb begin
    code2 = C_NONE;
    attr2 = s2_attr;
    if (misal && dev2)                      code2 = C_ALIGN;
    else if (s2_perm_fault)                 code2 = C_PERM;
    else if (!s2_for_table && ifetch && dev2) code2 = C_IDEV;
    else if (s2_for_table && dev2) begin
      if (ptw_protect) code2 = C_PERM;
      else             attr2 = NC_ATTR;
    end
  end

  wire run2 = (code1 == C_NONE) && s2_en;

  always_comb begin
    code  = code1;
    stage = 1'b0;
    attr  = s1_attr;
    if (run2) begin
      code  = code2;
      stage = code2 != C_NONE;
      attr  = attr2;
    end
    if (code == C_NONE && dbg_ok && dbg_hit) begin
      code  = C_DBG;
      stage = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_code    <= C_NONE;
      out_stage   <= 1'b0;
      out_attr    <= '0;
      out_guarded <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_code    <= code;
        out_stage   <= stage;
        out_attr    <= attr;
        out_guarded <= s1_en && ifetch && s1_guard;
      end
    end
  end
endmodule

module xlat_result_chk_props (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       s1_mmu_en,
  input logic       s2_present,
  input logic       out_valid,
  input logic [2:0] out_code,
  input logic       out_stage,
  input logic       out_guarded
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_code) && $stable(out_stage) && !out_valid));
  assert_guard_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !s1_mmu_en) |=> !out_guarded);
  assert_no_s2_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !s2_present) |=> !out_stage);
  assert_debug_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_code == 3'd3) |-> !out_stage);
  assert_code_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_code <= 3'd4);
endmodule

bind xlat_result_chk xlat_result_chk_props u_props (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .s1_mmu_en(s1_mmu_en),
  .s2_present(s2_present), .out_valid(out_valid), .out_code(out_code),
  .out_stage(out_stage), .out_guarded(out_guarded)
);

// File: tb/tb_xlat_result_chk.sv
module tb_xlat_result_chk;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic in_valid = 0, aligned = 1, lsm_access = 0, lsm_trap_dis = 1;
  logic s1_mmu_en = 0, s2_present = 0, trap_general = 0, dflt_cache = 0, s2_vm = 0;
  logic s1_perm_fault = 0, s1_guard = 0, s2_perm_fault = 0, s2_for_table = 0;
  logic ptw_protect = 0, dbg_hit = 0;
  logic [2:0] acc_type = 0;
  logic [5:0] s1_attr = 0, s2_attr = 0;
  logic out_valid, out_stage, out_guarded;
  logic [2:0] out_code;
  logic [5:0] out_attr;

  xlat_result_chk dut (.*);

  int checks = 0, fails = 0;
  logic [10:0] exp_res = 0;
  logic        exp_vld = 0;

  // returns {code, stage, attr, guard}
  function automatic logic [10:0] model();
    int code = 0, stg = 0;
    logic [5:0] at = s1_attr;
    bit s1on = s1_mmu_en && (!s2_present || (!trap_general && !dflt_cache));
    bit fetch = acc_type == 2;
    bit bad = (!aligned && !fetch) || acc_type == 3;
    bit g = s1on && fetch && s1_guard;
    if (lsm_access && s1_attr[5] && !s1_attr[4] && !lsm_trap_dis) code = 1;
    else if (bad && s1_attr[5]) code = 1;
    else if (s1on && s1_perm_fault) code = 2;
    else if (fetch && s1_attr[5]) code = 4;
    if (code == 0 && s2_present && (s2_vm || dflt_cache)) begin
      at = s2_attr;
      if (bad && s2_attr[5]) code = 1;
      else if (s2_perm_fault) code = 2;
      else if (!s2_for_table && fetch && s2_attr[5]) code = 4;
      else if (s2_for_table && s2_attr[5]) begin
        if (ptw_protect) code = 2; else at = 6'b001111;
      end
      if (code != 0) stg = 1;
    end
    if (code == 0 && dbg_hit && !(acc_type inside {4, 5, 6})) begin code = 3; stg = 0; end
    return {code[2:0], stg[0], at, g};
  endfunction

  function automatic string tag_of(logic [10:0] r);
    case (r[10:8]) 1: return "R3"; 2: return "R4/R7"; 3: return "R8"; 4: return "R5";
      default: return "R9"; endcase
  endfunction

  task automatic compare(string tag);
    logic [10:0] act = {out_code, out_stage, out_attr, out_guarded};
    checks++;
    if (out_valid !== exp_vld || act !== exp_res) begin
      fails++;
      $display("FAIL %s: valid=%0b res=%h expected valid=%0b res=%h", tag, out_valid, act, exp_vld, exp_res);
    end
  endtask

  // drive at negedge, advance model; compare at the following negedge
  task automatic step(bit v);
    in_valid = v;
    exp_vld  = v;
    if (v) exp_res = model();
    @(negedge clk);
  endtask

  task automatic clean();
    acc_type = 0; aligned = 1; lsm_access = 0; lsm_trap_dis = 1;
    s1_mmu_en = 1; s2_present = 1; trap_general = 0; dflt_cache = 0; s2_vm = 1;
    s1_attr = 6'b000000; s2_attr = 6'b000000; s1_perm_fault = 0; s1_guard = 0;
    s2_perm_fault = 0; s2_for_table = 0; ptw_protect = 0; dbg_hit = 0;
  endtask

  task automatic directed(string tag);
    step(1); compare(tag);
  endtask

  initial begin
    #1600000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    clean(); directed("R9 clean result");
    clean(); s1_attr = 6'b100000; lsm_access = 1; lsm_trap_dis = 0; directed("R3 lsm trap");
    clean(); s1_attr = 6'b110000; lsm_access = 1; lsm_trap_dis = 0; directed("R3 lsm on gre device");
    clean(); s1_attr = 6'b100000; aligned = 0; directed("R3 unaligned device");
    clean(); s1_attr = 6'b100000; acc_type = 3; directed("R3 zero-block device");
    clean(); s1_attr = 6'b100000; acc_type = 2; aligned = 0; directed("R5 unaligned fetch is idev");
    clean(); s1_perm_fault = 1; directed("R4 s1 perm");
    clean(); s1_mmu_en = 0; s1_perm_fault = 1; directed("R4 perm ignored s1 off");
    clean(); trap_general = 1; s1_perm_fault = 1; acc_type = 2; s1_guard = 1; directed("R2 s1 disabled by trap-general");
    clean(); acc_type = 2; s1_guard = 1; directed("R2 guarded fetch");
    clean(); s2_attr = 6'b100000; aligned = 0; directed("R6 s2 align");
    clean(); s2_perm_fault = 1; directed("R6 s2 perm");
    clean(); s2_vm = 0; s2_perm_fault = 1; directed("R6 s2 disabled");
    clean(); s2_vm = 0; dflt_cache = 1; s2_perm_fault = 1; directed("R6 s2 on by default-cacheable");
    clean(); s1_perm_fault = 1; s2_perm_fault = 1; directed("R6 s2 skipped after s1 fault");
    clean(); acc_type = 2; s2_attr = 6'b100000; directed("R5 s2 idev");
    clean(); s2_for_table = 1; s2_attr = 6'b110000; ptw_protect = 1; directed("R7 protected table fetch");
    clean(); s2_for_table = 1; s2_attr = 6'b110000; directed("R7 table fetch rewrite");
    clean(); s2_for_table = 1; acc_type = 2; s2_attr = 6'b100000; directed("R7 table fetch no idev");
    clean(); dbg_hit = 1; directed("R8 debug");
    clean(); dbg_hit = 1; acc_type = 5; directed("R8 debug skipped for icache op");
    clean(); dbg_hit = 1; s1_perm_fault = 1; directed("R10 debug masked");
    clean(); s1_perm_fault = 1; step(0); compare("R1 hold");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      acc_type = r[2:0]; aligned = r[3] | r[4]; lsm_access = r[5] & r[6];
      lsm_trap_dis = r[7]; s1_mmu_en = r[8] | r[9]; s2_present = r[10] | r[11];
      trap_general = r[12] & r[13]; dflt_cache = r[14] & r[15]; s2_vm = r[16] | r[17];
      s1_attr = {r[18] & r[19], r[20], r[21], r[22], r[23], r[24]};
      s1_perm_fault = r[25] & r[26] & r[27]; s1_guard = r[28];
      s2_attr = $urandom; s2_perm_fault = r[29] & r[30]; s2_for_table = r[31];
      ptw_protect = $urandom; dbg_hit = ($urandom % 4) == 0;
      step(($urandom % 5) != 0);
      compare(tag_of(exp_res));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule